// File: doc/BRIEF.md
# Jittered Sampling Averager

This block paces an ADC with sample-request strobes whose spacing is a programmable base interval plus a pseudo-random extra delay. Because the spacing keeps changing, a sampling rate far below the Nyquist rate of the inverter ripple does not phase-lock onto that ripple, so the ripple averages out instead of folding into a steady error. The pseudo-random delay comes from a 16-bit maximal-length shift-register generator that steps once per strobe.

Every ADC result that arrives with its valid flag is handled in two ways. It is kept at once as the instantaneous reading, which drives a sticky over-current flag for fast protection. It is also folded into an exponentially weighted running average that feeds charge counting. A decimated strobe fires after every M accepted readings and presents the average at that point. This allows fast oversampling to be reduced to a few dozen averaged results per second.

Top module: `jittered_sampler`

## Requirements
- R1: The jitter generator is a 16-bit right-shifting Galois register. In each step the register shifts right by one. If the bit shifted out was 1, the result is XORed with 0xB400. At reset the register loads `seed`, or 0xACE1 if `seed` is zero. It steps exactly once at each strobe, and the jitter used at that strobe is the register value before the step ANDed with `jitter_mask`.
- R2: Cycle 0 is the first clock cycle after reset is released. `sample_req` is first high in cycle `base_interval`. After a strobe in cycle n, the next strobe is in cycle n + 1 + `base_interval` + jitter, where jitter is defined in R1.
- R3: With `base_interval` = 0 and a jitter of zero, `sample_req` stays high in every cycle.
- R4: In the cycle after `adc_valid` is high, `inst_value` equals the `adc_data` of that cycle. Without `adc_valid`, `inst_value` holds its value.
- R5: On each accepted reading d, the average a becomes a + floor((d − a) / 2^k). The new value is visible in the next cycle, and the average is otherwise held.
- R6: The effective k is `shift_sel` limited to the range 1 to 8: a value of 0 acts as 1, and values above 8 act as 8.
- R7: `avg_strobe` pulses for one cycle, in the cycle after every M-th accepted reading. In that cycle `dec_value` equals the updated average, and it holds that value until the next pulse. A `decim_ratio` of 0 acts as 1.
- R8: In the cycle after an accepted reading whose magnitude is strictly greater than `oc_threshold`, `oc_flag` is high. The magnitude of the most negative code is 2^(DATA_W−1). A magnitude equal to the threshold does not set the flag.
- R9: `oc_flag` stays high until a cycle in which `oc_clear` is high and no reading over the threshold arrives. It then reads low in the next cycle. If a clear and an over-threshold reading arrive together, the flag stays set.
- R10: While reset is asserted, `inst_value`, the average, `dec_value`, `avg_strobe` and `oc_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_interval | input | IVL_W | Fixed part of the strobe spacing |
| jitter_mask | input | IVL_W | Mask applied to the generator value |
| seed | input | 16 | Generator start value (zero selects 0xACE1) |
| shift_sel | input | 4 | Averaging shift k |
| decim_ratio | input | DEC_W | Accepted readings per decimated output |
| oc_threshold | input | DATA_W | Unsigned over-current magnitude limit |
| oc_clear | input | 1 | Clears the over-current flag |
| adc_valid | input | 1 | ADC result valid |
| adc_data | input | DATA_W | Signed ADC result |
| sample_req | output | 1 | Sample request strobe |
| inst_value | output | DATA_W | Latest reading |
| avg_value | output | DATA_W | Running weighted average |
| avg_strobe | output | 1 | Decimated output pulse |
| dec_value | output | DATA_W | Average captured at the last decimated pulse |
| oc_flag | output | 1 | Sticky over-current flag |

## Verification
The strobe output is combinational from the interval counter. It is therefore compared in the same cycle that the bench's independent generator model predicts. Every reading, average, decimation and over-current result comes through exactly one register, so each one is compared one cycle after the reading is driven. The bench drives its inputs and compares the outputs at the falling edge. Its model takes one step per rising edge, so each comparison sees exactly the state that the last edge produced.

// File: rtl/jsa_pkg.sv
`timescale 1ns/1ps
package jsa_pkg;
    localparam int            GEN_W        = 16;
    localparam logic [15:0]   GEN_TAPS     = 16'hB400;
    localparam logic [15:0]   GEN_FALLBACK = 16'hACE1;

    typedef enum logic [1:0] {
        OC_HOLD  = 2'd0,
        OC_SET   = 2'd1,
        OC_CLEAR = 2'd2
    } oc_action_e;

    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
        logic [GEN_W-1:0] sh;
        sh = s >> 1;
        return s[0] ? (sh ^ GEN_TAPS) : sh;
    endfunction

    function automatic logic [GEN_W-1:0] gen_start(input logic [GEN_W-1:0] s);
        return (s == '0) ? GEN_FALLBACK : s;
    endfunction
endpackage

// File: rtl/jsa_lfsr.sv
`timescale 1ns/1ps
module jsa_lfsr
    import jsa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [GEN_W-1:0] seed,
    input  logic             advance,
    output logic [GEN_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)          state <= gen_start(seed);
        else if (advance) state <= gen_step(state);
    end
endmodule

// File: rtl/jsa_interval_timer.sv
`timescale 1ns/1ps
module jsa_interval_timer
    import jsa_pkg::*;
#(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IVL_W-1:0] base,
    input  logic [IVL_W-1:0] mask,
    input  logic [GEN_W-1:0] rnd,
    output logic             fire
);
    localparam int CNT_W = IVL_W + 1;

    logic [IVL_W-1:0] rnd_fit;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;

    generate
        if (IVL_W <= GEN_W) begin : g_trunc
            assign rnd_fit = rnd[IVL_W-1:0];
        end else begin : g_pad
            assign rnd_fit = {{(IVL_W-GEN_W){1'b0}}, rnd};
        end
    endgenerate

    assign reload = {1'b0, base} + {1'b0, mask & rnd_fit};
    assign fire   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= {1'b0, base};
        else if (fire) cnt <= reload;
        else           cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/jsa_ema.sv
`timescale 1ns/1ps
module jsa_ema #(
    parameter int DATA_W = 12,
    parameter int K_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic signed [DATA_W-1:0] sample,
    input  logic [K_W-1:0]           shift,
    output logic signed [DATA_W-1:0] avg,
    output logic signed [DATA_W-1:0] avg_nxt
);
    logic signed [DATA_W:0] diff;
    logic signed [DATA_W:0] step;
    logic signed [DATA_W:0] sum;

    always_comb begin
        diff    = {sample[DATA_W-1], sample} - {avg[DATA_W-1], avg};
        step    = diff >>> shift;
        sum     = {avg[DATA_W-1], avg} + step;
        avg_nxt = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       avg <= '0;
        else if (load) avg <= avg_nxt;
    end
endmodule

// File: rtl/jsa_decimator.sv
`timescale 1ns/1ps
module jsa_decimator #(
    parameter int DATA_W = 12,
    parameter int DEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DEC_W-1:0]  ratio,
    input  logic [DATA_W-1:0] avg_in,
    output logic              tick,
    output logic [DATA_W-1:0] held
);
    logic [DEC_W-1:0] eff;
    logic [DEC_W-1:0] cnt;
    logic             last;

    assign eff  = (ratio == '0) ? DEC_W'(1) : ratio;
    assign last = (cnt >= eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
            held <= '0;
        end else if (take && last) begin
            cnt  <= '0;
            tick <= 1'b1;
            held <= avg_in;
        end else begin
            tick <= 1'b0;
            if (take) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/jittered_sampler.sv
`timescale 1ns/1ps
module jittered_sampler
    import jsa_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int IVL_W  = 16,
    parameter int DEC_W  = 8,
    parameter int K_MAX  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IVL_W-1:0]  base_interval,
    input  logic [IVL_W-1:0]  jitter_mask,
    input  logic [15:0]       seed,
    input  logic [3:0]        shift_sel,
    input  logic [DEC_W-1:0]  decim_ratio,
    input  logic [DATA_W-1:0] oc_threshold,
    input  logic              oc_clear,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_data,
    output logic              sample_req,
    output logic [DATA_W-1:0] inst_value,
    output logic [DATA_W-1:0] avg_value,
    output logic              avg_strobe,
    output logic [DATA_W-1:0] dec_value,
    output logic              oc_flag
);
    localparam int K_W = 4;

    logic [GEN_W-1:0]         gen_state;
    logic [K_W-1:0]           k_eff;
    logic signed [DATA_W-1:0] avg_q;
    logic signed [DATA_W-1:0] avg_nxt;
    logic [DATA_W-1:0]        magnitude;
    oc_action_e               oc_act;

    jsa_lfsr u_gen (
        .clk     (clk),
        .rst     (rst),
        .seed    (seed),
        .advance (sample_req),
        .state   (gen_state)
    );

    jsa_interval_timer #(.IVL_W(IVL_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .base (base_interval),
        .mask (jitter_mask),
        .rnd  (gen_state),
        .fire (sample_req)
    );

    always_comb begin
        if (shift_sel == '0)                 k_eff = K_W'(1);
        else if (shift_sel > K_W'(K_MAX))    k_eff = K_W'(K_MAX);
        else                                 k_eff = shift_sel;
    end

    jsa_ema #(.DATA_W(DATA_W), .K_W(K_W)) u_ema (
        .clk     (clk),
        .rst     (rst),
        .load    (adc_valid),
        .sample  (adc_data),
        .shift   (k_eff),
        .avg     (avg_q),
        .avg_nxt (avg_nxt)
    );

    assign avg_value = avg_q;

    jsa_decimator #(.DATA_W(DATA_W), .DEC_W(DEC_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .take   (adc_valid),
        .ratio  (decim_ratio),
        .avg_in (avg_nxt),
        .tick   (avg_strobe),
        .held   (dec_value)
    );

    assign magnitude = adc_data[DATA_W-1] ? (~adc_data + 1'b1) : adc_data;

    always_comb begin
        if (adc_valid && (magnitude > oc_threshold)) oc_act = OC_SET;
        else if (oc_clear)                           oc_act = OC_CLEAR;
        else                                         oc_act = OC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inst_value <= '0;
            oc_flag    <= 1'b0;
        end else begin
            if (adc_valid) inst_value <= adc_data;
            case (oc_act)
                OC_SET:   oc_flag <= 1'b1;
                OC_CLEAR: oc_flag <= 1'b0;
                default:  oc_flag <= oc_flag;
            endcase
        end
    end
endmodule

// File: rtl/jittered_sampler_chk.sv
`timescale 1ns/1ps
module jittered_sampler_chk #(
    parameter int DATA_W = 12,
    parameter int IVL_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [IVL_W-1:0]  base_interval,
    input logic [DATA_W-1:0] oc_threshold,
    input logic              oc_clear,
    input logic              adc_valid,
    input logic [DATA_W-1:0] adc_data,
    input logic              sample_req,
    input logic [DATA_W-1:0] inst_value,
    input logic [DATA_W-1:0] avg_value,
    input logic              avg_strobe,
    input logic [DATA_W-1:0] dec_value,
    input logic              oc_flag
);
    int mag_i;
    always_comb mag_i = ($signed(adc_data) < 0) ? -int'($signed(adc_data)) : int'($signed(adc_data));

    p_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (sample_req && base_interval != '0) |=> !sample_req);

    p_inst_load_r4: assert property (@(posedge clk) disable iff (rst)
        adc_valid |=> (inst_value == $past(adc_data)));

    p_inst_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> $stable(inst_value));

    p_avg_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (adc_valid && $signed(adc_data) >= $signed(avg_value)) |=>
        ($signed(avg_value) >= $signed($past(avg_value)) &&
         $signed(avg_value) <= $signed($past(adc_data))));

    p_avg_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (adc_valid && $signed(adc_data) < $signed(avg_value)) |=>
        ($signed(avg_value) <= $signed($past(avg_value)) &&
         $signed(avg_value) >= $signed($past(adc_data))));

    p_avg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> $stable(avg_value));

    p_dec_match_r7: assert property (@(posedge clk) disable iff (rst)
        avg_strobe |-> (dec_value == avg_value));

    p_dec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !avg_strobe |=> (avg_strobe || $stable(dec_value)));

    p_oc_set_r8: assert property (@(posedge clk) disable iff (rst)
        (adc_valid && mag_i > int'(oc_threshold)) |=> oc_flag);

    p_oc_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (oc_flag && !oc_clear) |=> oc_flag);
endmodule

bind jittered_sampler jittered_sampler_chk #(.DATA_W(DATA_W), .IVL_W(IVL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .base_interval (base_interval),
    .oc_threshold  (oc_threshold),
    .oc_clear      (oc_clear),
    .adc_valid     (adc_valid),
    .adc_data      (adc_data),
    .sample_req    (sample_req),
    .inst_value    (inst_value),
    .avg_value     (avg_value),
    .avg_strobe    (avg_strobe),
    .dec_value     (dec_value),
    .oc_flag       (oc_flag)
);

// File: tb/jittered_sampler_bench.sv
`timescale 1ns/1ps
module jittered_sampler_bench;
    localparam int DW = 12;
    localparam int IW = 16;
    localparam int MW = 8;
    localparam int RUN = 400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] base_interval = '0;
    logic [IW-1:0] jitter_mask = '0;
    logic [15:0]   seed = 16'h1;
    logic [3:0]    shift_sel = 4'd1;
    logic [MW-1:0] decim_ratio = 8'd1;
    logic [DW-1:0] oc_threshold = '0;
    logic          oc_clear = 1'b0;
    logic          adc_valid = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          sample_req;
    logic [DW-1:0] inst_value, avg_value, dec_value;
    logic          avg_strobe, oc_flag;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    jittered_sampler u_jittered_sampler (
        .clk(clk), .rst(rst), .base_interval(base_interval), .jitter_mask(jitter_mask),
        .seed(seed), .shift_sel(shift_sel), .decim_ratio(decim_ratio),
        .oc_threshold(oc_threshold), .oc_clear(oc_clear), .adc_valid(adc_valid),
        .adc_data(adc_data), .sample_req(sample_req), .inst_value(inst_value),
        .avg_value(avg_value), .avg_strobe(avg_strobe), .dec_value(dec_value),
        .oc_flag(oc_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] model_gen(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ ({16{s[0]}} & 16'hB400);
    endfunction

    function automatic int sx(input logic [DW-1:0] v);
        return int'($signed(v));
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int masks[4] = '{0, 3, 7, 15};
        for (int cfg = 0; cfg < 16; cfg++) begin
            int base, msk, ke, me, thr, pat;
            int m_inst, m_avg, m_dec, m_stb, m_oc, m_cnt, gap, target, rs;
            bit prev_clr;
            logic [15:0] gen;
            base = cfg % 4;
            msk  = masks[(cfg / 4) % 4];
            thr  = (cfg * 131) % 2000 + 10;
            pat  = cfg % 4;
            @(negedge clk);
            rst           = 1'b1;
            base_interval = IW'(base);
            jitter_mask   = IW'(msk);
            seed          = (cfg == 3 || cfg == 9) ? 16'h0 : 16'(cfg * 4099 + 1);
            shift_sel     = 4'(cfg);
            decim_ratio   = MW'(cfg % 5);
            oc_threshold  = DW'(thr);
            adc_valid     = 1'b0;
            oc_clear      = 1'b0;
            ke = (cfg == 0) ? 1 : (cfg > 8 ? 8 : cfg);
            me = (cfg % 5 == 0) ? 1 : cfg % 5;
            gen = (seed == 16'h0) ? 16'hACE1 : seed;
            m_inst = 0; m_avg = 0; m_dec = 0; m_stb = 0; m_oc = 0; m_cnt = 0;
            gap = 0; target = base; rs = 32'h1234_5 + cfg; prev_clr = 0;
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            // R10: reset state seen before the first post-reset edge
            chk(inst_value == '0, "R10", sx(inst_value), 0);
            chk(avg_value == '0, "R10", sx(avg_value), 0);
            chk(dec_value == '0 && !avg_strobe, "R10", sx(dec_value), 0);
            chk(!oc_flag, "R10", int'(oc_flag), 0);
            rst = 1'b0;
            for (int t = 0; t < RUN; t++) begin
                bit v, clr, exp_req;
                int d, mag;
                string rq;
                // compare
                exp_req = (gap == target);
                rq = (base == 0 && msk == 0) ? "R3" : (msk != 0 ? "R1" : "R2");
                chk(sample_req == exp_req, rq, int'(sample_req), int'(exp_req));
                chk(sx(inst_value) == m_inst, "R4", sx(inst_value), m_inst);
                chk(sx(avg_value) == m_avg, (cfg == 0 || cfg > 8) ? "R6" : "R5", sx(avg_value), m_avg);
                chk(int'(avg_strobe) == m_stb, "R7", int'(avg_strobe), m_stb);
                chk(sx(dec_value) == m_dec, "R7", sx(dec_value), m_dec);
                chk(int'(oc_flag) == m_oc, prev_clr ? "R9" : "R8", int'(oc_flag), m_oc);
                // strobe model
                if (exp_req) begin
                    target = 1 + base + int'(gen & 16'(msk));
                    gen = model_gen(gen);
                    gap = 1;
                end else begin
                    gap++;
                end
                // stimulus
                v   = ((t * 7 + cfg) % 3) != 0;
                clr = (t % 29) == 28;
                rs  = rs ^ (rs << 13); rs = rs ^ (rs >>> 17); rs = rs ^ (rs << 5);
                case (pat)
                    0: d = ((t * 37) % 4096) - 2048;
                    1: d = (t % 2 == 1) ? -2048 : 2047;
                    2: d = (t < 200) ? thr : ((t < 300) ? thr + 1 : -(thr + 1));
                    default: d = (rs & 4095) - 2048;
                endcase
                adc_valid = v;
                adc_data  = DW'(d);
                oc_clear  = clr;
                // register model
                mag = (d < 0) ? -d : d;
                if (v && mag > thr) m_oc = 1;
                else if (clr)       m_oc = 0;
                prev_clr = clr;
                m_stb = 0;
                if (v) begin
                    int diff;
                    m_inst = d;
                    diff = d - m_avg;
                    m_avg = m_avg + (diff >>> ke);
                    m_cnt++;
                    if (m_cnt >= me) begin
                        m_cnt = 0;
                        m_stb = 1;
                        m_dec = m_avg;
                    end
                end
                @(negedge clk);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule